// File: doc/BRIEF.md
# Strobed Slave-FIFO Read Controller

This block sits in an external device and pulls bytes out of a peripheral's slave FIFO over an asynchronous strobe interface. It drives a FIFO select address and active-low chip select, output enable and read strobe, and it samples an 8-bit data bus. A host starts a transfer with a one-cycle `start` pulse and a byte count. The controller then sets up the address and select, and issues one strobe pulse for each byte. Before every strobe it checks the peripheral's empty flag. Each captured byte appears on `rd_data` with a one-cycle `rd_valid` pulse. A one-cycle `done` pulse ends the transfer, and `rd_count` holds the number of bytes actually read.

All interface timing is counted in local clock cycles and set by parameters. These are the address/select setup before the strobe, the strobe's low and high widths, the data-valid delay after the strobe falls, and the address/select hold after the last strobe. Output enable is driven separately from the strobe. During setup the bus therefore shows the peripheral's previous byte, and the controller never takes that byte as new data. A byte is sampled only at the end of a strobe's low phase, once the data-valid delay has elapsed. The empty flag must be synchronous to `clk`.

Top module: `fifo_rd_master`

## Requirements
- R1: `fifo_addr` equals the address given with `start` and stays constant for as long as `cs_n` is low. `cs_n` is low for at least T_SETUP cycles before `rd_n` falls.
- R2: `rd_n` is never low while `cs_n` is high. Chip select falls together with or before the strobe.
- R3: Each `rd_n` low phase lasts at least max(T_LOW, T_VALID) cycles.
- R4: `rd_valid` pulses exactly once per strobe, on the cycle after `rd_n` returns high. `rd_data` then equals the byte the peripheral presented during that strobe. The stale byte shown while only output enable is low is never reported.
- R5: Between successive strobes of one transfer, `rd_n` stays high for at least T_HIGH cycles.
- R6: `oe_n` is low whenever `rd_n` is low, and high whenever `cs_n` is high.
- R7: After the last strobe rises, `cs_n` and `fifo_addr` are held for at least T_HOLD cycles.
- R8: With enough bytes available, a transfer of N bytes issues N strobes and delivers the bytes in FIFO order. It then pulses `done` for one cycle with `cs_n` high and `rd_count` = N.
- R9: `fifo_empty` (active high) is checked before every strobe. If it is set, the transfer ends without that strobe, and `rd_count` equals the number of bytes read, which may be zero.
- R10: A `burst_len` of 0 gives a `done` pulse with `rd_count` = 0 and no strobe.
- R11: During and right after reset, `cs_n`, `oe_n` and `rd_n` are high, and `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer (taken when idle) |
| rd_addr_in | input | AW | FIFO select address for the transfer |
| burst_len | input | CNT_W | Number of bytes to read |
| fifo_empty | input | 1 | Peripheral empty flag, active high, synchronous to clk |
| bus_in | input | DW | Data bus from the peripheral |
| fifo_addr | output | AW | FIFO select address to the peripheral |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| rd_data | output | DW | Last captured byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rd_count | output | CNT_W | Bytes read in the current or last transfer |

## Verification
The bench uses a behavioural peripheral with a byte queue. The peripheral drives a marker byte until the data-valid delay has passed and a stale byte while only output enable is low, so an early or mistimed capture shows up as a data mismatch. Single-byte and multi-byte transfers with ample data check ordering and strobe timing. A transfer longer than the available data, and one that starts with the peripheral already empty, separate the empty-flag stop from a normal finish. A zero-length request, and transfers that drain bytes left over from an earlier short transfer, show that the count and the FIFO order carry across transfer boundaries.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CHECK,
    ST_STROBE,
    ST_RECOVER,
    ST_HOLD,
    ST_FINISH
  } rdm_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rdm_timer.sv
module rdm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/rdm_capture.sv
module rdm_capture #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic [DW-1:0]    bus,
  output logic [DW-1:0]    data,
  output logic             valid,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      count <= '0;
    end else begin
      valid <= take;
      if (take) data <= bus;
      if (clear)     count <= '0;
      else if (take) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_rd_master.sv
module fifo_rd_master
  import rdm_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int CNT_W   = 8,
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_VALID = 2,
  parameter int T_HIGH  = 2,
  parameter int T_HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    rd_addr_in,
  input  logic [CNT_W-1:0] burst_len,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    bus_in,
  output logic [AW-1:0]    fifo_addr,
  output logic             cs_n,
  output logic             oe_n,
  output logic             rd_n,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [CNT_W-1:0] rd_count
);
  localparam int LOW_CYC = max2(T_LOW, T_VALID);
  localparam int MAX_D   = max2(max2(T_SETUP, LOW_CYC), max2(T_HIGH, T_HOLD));
  localparam int TW      = $clog2(MAX_D + 1) + 1;
  localparam logic [TW-1:0] D_SETUP = TW'(T_SETUP - 1);
  localparam logic [TW-1:0] D_LOW   = TW'(LOW_CYC - 1);
  localparam logic [TW-1:0] D_HIGH  = TW'(T_HIGH - 1);
  localparam logic [TW-1:0] D_HOLD  = TW'(T_HOLD - 1);

  rdm_state_t     st, nxt;
  logic           tmr_load, tmr_zero, take, clear;
  logic [TW-1:0]  tmr_val;
  logic [CNT_W-1:0] len_q;

  rdm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  rdm_capture #(.DW(DW), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .clear(clear), .take(take), .bus(bus_in),
    .data(rd_data), .valid(rd_valid), .count(rd_count)
  );

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    clear    = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        clear = 1'b1;
        if (burst_len == '0) nxt = ST_FINISH;
        else begin
          nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = D_SETUP;
        end
      end
      ST_SETUP: if (tmr_zero) nxt = ST_CHECK;
      ST_CHECK: begin
        tmr_load = 1'b1;
        if (fifo_empty) begin nxt = ST_HOLD;   tmr_val = D_HOLD; end
        else            begin nxt = ST_STROBE; tmr_val = D_LOW;  end
      end
      ST_STROBE: if (tmr_zero) begin
        take = 1'b1; nxt = ST_RECOVER; tmr_load = 1'b1; tmr_val = D_HIGH;
      end
      ST_RECOVER: if (tmr_zero) begin
        if (rd_count == len_q) begin
          nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = D_HOLD;
        end else nxt = ST_CHECK;
      end
      ST_HOLD:   if (tmr_zero) nxt = ST_FINISH;
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      len_q     <= '0;
      fifo_addr <= '0;
      cs_n      <= 1'b1;
      oe_n      <= 1'b1;
      rd_n      <= 1'b1;
      done      <= 1'b0;
    end else begin
      st   <= nxt;
      if (st == ST_IDLE && start) begin
        len_q     <= burst_len;
        fifo_addr <= rd_addr_in;
      end
      cs_n <= !(nxt inside {ST_SETUP, ST_CHECK, ST_STROBE, ST_RECOVER, ST_HOLD});
      oe_n <= !(nxt inside {ST_SETUP, ST_CHECK, ST_STROBE, ST_RECOVER});
      rd_n <= !(nxt == ST_STROBE);
      done <= (nxt == ST_FINISH);
    end
  end

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(fifo_addr));
  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);
  assert_capture_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!rd_n) && rd_n));
  assert_oe_covers_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !oe_n);
  assert_done_deselected_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && rd_n));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_FINISH) |-> (rd_count <= len_q));
endmodule

// File: tb/tb_fifo_rd_master.sv
module tb_fifo_rd_master;
  localparam int DW = 8, AW = 2, CNT_W = 8;
  localparam int T_SETUP = 2, T_LOW = 3, T_VALID = 2, T_HIGH = 2, T_HOLD = 2;
  localparam int LOW_CYC = (T_LOW > T_VALID) ? T_LOW : T_VALID;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] rd_addr_in = '0;
  logic [CNT_W-1:0] burst_len = '0;
  logic fifo_empty = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [AW-1:0] fifo_addr;
  logic cs_n, oe_n, rd_n, rd_valid, done;
  logic [DW-1:0] rd_data;
  logic [CNT_W-1:0] rd_count;

  always #2.5 clk = ~clk;

  fifo_rd_master #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .T_SETUP(T_SETUP), .T_LOW(T_LOW),
    .T_VALID(T_VALID), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_addr_in(rd_addr_in), .burst_len(burst_len),
    .fifo_empty(fifo_empty), .bus_in(bus_in), .fifo_addr(fifo_addr), .cs_n(cs_n),
    .oe_n(oe_n), .rd_n(rd_n), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .rd_count(rd_count));

  int errors = 0, checks = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] stale = 8'h5A;
  logic [AW-1:0] exp_addr = '0;
  int lo_cnt = 0, hi_cnt = 0, cs_cnt = 0, strobes_txn = 0;
  int strobe_total = 0, valid_total = 0;
  logic prev_rd = 1'b1, prev_cs = 1'b1, monitor_on = 1'b0;
  logic [DW-1:0] seed = 8'h30;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Peripheral model and per-cycle monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (monitor_on) begin
      if (!rd_n) chk(!cs_n, "R2 strobe while deselected", cs_n, 0);
      if (!rd_n) chk(!oe_n, "R6 oe during strobe", oe_n, 0);
      if (cs_n)  chk(oe_n, "R6 oe while deselected", oe_n, 1);
      if (!cs_n) chk(fifo_addr == exp_addr, "R1 address", fifo_addr, exp_addr);
      if (rd_valid) begin
        valid_total++;
        chk(q.size() > 0, "R4 capture without byte", q.size(), 1);
        if (q.size() > 0) chk(rd_data == q[0], "R4 captured byte", rd_data, q[0]);
      end
    end
    if (!rd_n && prev_rd) begin
      strobe_total++;
      if (monitor_on) begin
        chk(cs_cnt >= T_SETUP, "R1 setup cycles", cs_cnt, T_SETUP);
        if (strobes_txn > 0) chk(hi_cnt >= T_HIGH, "R5 high width", hi_cnt, T_HIGH);
      end
      strobes_txn++;
      lo_cnt = 0;
    end
    if (rd_n && !prev_rd) begin
      if (monitor_on) chk(lo_cnt >= LOW_CYC, "R3 low width", lo_cnt, LOW_CYC);
      if (q.size() > 0) stale = q.pop_front();
      hi_cnt = 0;
    end
    if (cs_n && !prev_cs) begin
      if (monitor_on && strobes_txn > 0) chk(hi_cnt >= T_HOLD, "R7 hold cycles", hi_cnt, T_HOLD);
      strobes_txn = 0;
    end
    if (!rd_n) lo_cnt++;
    if (rd_n && !cs_n) hi_cnt++;
    if (!cs_n) cs_cnt++; else cs_cnt = 0;
    prev_rd = rd_n;
    prev_cs = cs_n;
    fifo_empty <= (q.size() == 0);
    if (oe_n)       bus_in <= 8'h00;
    else if (!rd_n) bus_in <= (lo_cnt >= T_VALID && q.size() > 0) ? q[0] : 8'hEE;
    else            bus_in <= stale;
  end

  task automatic run(input logic [AW-1:0] a, input int len, input int push);
    int expn, s0, v0, waited;
    for (int i = 0; i < push; i++) begin q.push_back(seed); seed = seed + 8'd7; end
    @(negedge clk);
    @(negedge clk);
    expn = (len < q.size()) ? len : q.size();
    s0 = strobe_total; v0 = valid_total;
    exp_addr = a;
    rd_addr_in = a; burst_len = CNT_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(cs_n == 1'b1, "R8 deselected at done", cs_n, 1);
    chk(rd_count == CNT_W'(expn), (len == 0) ? "R10 count" : "R9 R8 count", rd_count, expn);
    chk(strobe_total - s0 == expn, "R8 strobes", strobe_total - s0, expn);
    chk(valid_total - v0 == expn, "R4 valid pulses", valid_total - v0, expn);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && oe_n && rd_n, "R11 strobes idle in reset", {cs_n, oe_n, rd_n}, 7);
    chk(!rd_valid && !done, "R11 flags low in reset", {rd_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && oe_n && rd_n, "R11 strobes idle after reset", {cs_n, oe_n, rd_n}, 7);
    monitor_on = 1'b1;
    run(2'd1, 1, 1);   // single read
    run(2'd2, 4, 4);   // burst, exact supply
    run(2'd3, 5, 3);   // R9: empty stops burst early
    run(2'd0, 2, 0);   // R9: empty before first strobe
    run(2'd1, 0, 2);   // R10: zero length, two bytes left behind
    run(2'd2, 2, 0);   // drains leftovers in order
    run(2'd3, 6, 10);  // long burst, four left
    run(2'd0, 4, 0);   // remaining four
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule